// File: doc/BRIEF.md
# Microprogrammed Accumulator CPU

This block is a small 16-bit accumulator computer. A fixed control store of 20-bit microwords drives it, one microword per clock. A control address register selects the current microword, and a single-entry link register holds the return point of a microcode call. The datapath has four registers: an accumulator, a data register, an address register and a program counter. It also has a 2048-word main memory.

Every machine instruction starts with a shared three-step fetch routine. The fetch ends with a dispatch that turns the 4-bit opcode into a control-store entry point, at four microwords per opcode. Instructions with the indirect flag set call a shared microcode subroutine, which replaces the address operand with the word it points to. Four instructions are implemented: add to accumulator, branch when the accumulator is negative, store accumulator, and exchange accumulator with memory. Every other opcode falls straight back to fetch.

A program is placed in main memory through a direct load port before or during reset. A second read port lets the surroundings inspect memory contents. No data stream crosses the boundary, so every pin is a plain level or strobe with no valid/ready handshake and no back-pressure.

Top module: `ucode_acc_cpu`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, the control address is 64 (the fetch entry), the program counter is 0 and the accumulator is 0.
- R2: An instruction word has bit 15 as the indirect flag, bits 14..11 as the opcode and bits 10..0 as the operand address. Fetch takes three cycles at control addresses 64, 65 and 66. The program counter rises by one during the second of these. After the third, the control address is {0, opcode, 00}.
- R3: A microword is 20 bits: three 3-bit operation fields F1, F2 and F3, then a 2-bit condition CD, a 2-bit branch kind BR and a 7-bit target AD. The value 000 in any operation field does nothing, and no microword issues more than one accumulator-writing operation.
- R4: BR=01 with a true condition loads the control address from AD and the link register with the current address plus one. BR=10 loads the control address from the link register. With the indirect flag set, the effective address is bits 10..0 of the memory word at the operand address; otherwise it is the operand address itself.
- R5: Opcode 0 adds the word at the effective address to the accumulator, modulo 2^16.
- R6: Opcode 1 loads the program counter with the effective address when accumulator bit 15 is 1. Otherwise the program counter keeps the value the fetch left.
- R7: Opcode 2 writes the accumulator to the effective address and leaves the accumulator unchanged.
- R8: Opcode 3 swaps the accumulator with the memory word at the effective address.
- R9: Opcodes 4 to 15 change neither the accumulator nor memory, whatever their indirect flag and address are, and execution continues with the next word.
- R10: A high load strobe writes the load data to the load address on the rising clock edge, including during reset. The peek output always shows the memory word at the peek address.
- R11: CD selects the tested condition: 00 always true, 01 data register bit 15, 10 accumulator bit 15, 11 accumulator equal to zero. A jump (BR=00) or call whose condition is false moves the control address to the current address plus one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Direct memory write strobe |
| load_addr | input | 11 | Word address for the direct write |
| load_data | input | 16 | Data for the direct write |
| peek_addr | input | 11 | Word address for the inspection read |
| peek_data | output | 16 | Memory word at peek_addr |
| ac_out | output | 16 | Accumulator value |
| pc_out | output | 11 | Program counter value |
| car_out | output | 7 | Current control address |

## Verification
The assertions watch the sequencer on every cycle. They check that calls link and returns go back to the saved address, that false conditions fall through, that the dispatch after fetch lands on a four-aligned entry in the lower half of the control store, that the program counter steps during fetch, and that each microword has at most one accumulator writer, whose add result is checked. The end-to-end meaning of each instruction cannot be seen from any one cycle. This covers direct and indirect operands, a taken and a not-taken branch, the swap, and unused opcodes that must leave state alone. The bench's program shows it by comparing the program counter and accumulator at every fetch entry, then inspecting memory once the program settles into its final loop.

// File: rtl/ucpu_pkg.sv
package ucpu_pkg;
  localparam int DATA_W = 16;
  localparam int MA_W   = 11;
  localparam int CA_W   = 7;
  localparam int OP_W   = 4;
  localparam int FLD_W  = 3;
  localparam int FLD_N  = 3;
  localparam int DEC_N  = 1 << FLD_W;
  localparam int MAP_SH = CA_W - 1 - OP_W;

  typedef enum logic [1:0] {
    CD_ALW  = 2'b00,
    CD_IND  = 2'b01,
    CD_NEG  = 2'b10,
    CD_ZERO = 2'b11
  } cond_e;

  typedef enum logic [1:0] {
    BR_JMP  = 2'b00,
    BR_CALL = 2'b01,
    BR_RET  = 2'b10,
    BR_MAP  = 2'b11
  } br_e;

  typedef struct packed {
    logic [FLD_W-1:0] f1;
    logic [FLD_W-1:0] f2;
    logic [FLD_W-1:0] f3;
    cond_e            cd;
    br_e              br;
    logic [CA_W-1:0]  ad;
  } uword_t;

  // first operation field
  localparam logic [FLD_W-1:0] F1_NOP   = 3'd0;
  localparam logic [FLD_W-1:0] F1_ADD   = 3'd1;
  localparam logic [FLD_W-1:0] F1_CLRAC = 3'd2;
  localparam logic [FLD_W-1:0] F1_INCAC = 3'd3;
  localparam logic [FLD_W-1:0] F1_DRTAC = 3'd4;
  localparam logic [FLD_W-1:0] F1_DRTAR = 3'd5;
  localparam logic [FLD_W-1:0] F1_PCTAR = 3'd6;
  localparam logic [FLD_W-1:0] F1_WRITE = 3'd7;
  // second operation field
  localparam logic [FLD_W-1:0] F2_NOP   = 3'd0;
  localparam logic [FLD_W-1:0] F2_SUB   = 3'd1;
  localparam logic [FLD_W-1:0] F2_OR    = 3'd2;
  localparam logic [FLD_W-1:0] F2_AND   = 3'd3;
  localparam logic [FLD_W-1:0] F2_READ  = 3'd4;
  localparam logic [FLD_W-1:0] F2_ACTDR = 3'd5;
  localparam logic [FLD_W-1:0] F2_INCDR = 3'd6;
  localparam logic [FLD_W-1:0] F2_PCTDR = 3'd7;
  // third operation field
  localparam logic [FLD_W-1:0] F3_NOP   = 3'd0;
  localparam logic [FLD_W-1:0] F3_XOR   = 3'd1;
  localparam logic [FLD_W-1:0] F3_COM   = 3'd2;
  localparam logic [FLD_W-1:0] F3_SHL   = 3'd3;
  localparam logic [FLD_W-1:0] F3_SHR   = 3'd4;
  localparam logic [FLD_W-1:0] F3_INCPC = 3'd5;
  localparam logic [FLD_W-1:0] F3_ARTPC = 3'd6;

  localparam logic [OP_W-1:0] OP_ADD  = 4'd0;
  localparam logic [OP_W-1:0] OP_BRN  = 4'd1;
  localparam logic [OP_W-1:0] OP_STO  = 4'd2;
  localparam logic [OP_W-1:0] OP_XCH  = 4'd3;

  localparam logic [CA_W-1:0] FETCH_ORG = CA_W'(1) << (CA_W - 1);
  localparam logic [CA_W-1:0] INDIR_ORG = FETCH_ORG + CA_W'(3);
endpackage

// File: rtl/ucpu_field_dec.sv
module ucpu_field_dec #(
  parameter int W = 3
) (
  input  logic [W-1:0]      code,
  output logic [(1<<W)-1:0] hot
);
  always_comb begin
    hot       = '0;
    hot[code] = 1'b1;
  end
endmodule

// File: rtl/ucpu_ctrl_rom.sv
module ucpu_ctrl_rom
  import ucpu_pkg::*;
(
  input  logic [CA_W-1:0] addr,
  output uword_t          word
);
  localparam logic [CA_W-1:0] A_ADD = CA_W'(OP_ADD) << MAP_SH;
  localparam logic [CA_W-1:0] A_BRN = CA_W'(OP_BRN) << MAP_SH;
  localparam logic [CA_W-1:0] A_STO = CA_W'(OP_STO) << MAP_SH;
  localparam logic [CA_W-1:0] A_XCH = CA_W'(OP_XCH) << MAP_SH;

  function automatic uword_t mk(input logic [FLD_W-1:0] a, input logic [FLD_W-1:0] b,
                                input logic [FLD_W-1:0] c, input cond_e cd,
                                input br_e br, input logic [CA_W-1:0] ad);
    uword_t w;
    w.f1 = a;
    w.f2 = b;
    w.f3 = c;
    w.cd = cd;
    w.br = br;
    w.ad = ad;
    return w;
  endfunction

  always_comb begin
    case (addr)
      // add: resolve operand, read, accumulate
      A_ADD:              word = mk(F1_NOP,   F2_NOP,   F3_NOP,   CD_IND, BR_CALL, INDIR_ORG);
      A_ADD + CA_W'(1):   word = mk(F1_NOP,   F2_READ,  F3_NOP,   CD_ALW, BR_JMP,  A_ADD + CA_W'(2));
      A_ADD + CA_W'(2):   word = mk(F1_ADD,   F2_NOP,   F3_NOP,   CD_ALW, BR_JMP,  FETCH_ORG);
      // branch on negative accumulator
      A_BRN:              word = mk(F1_NOP,   F2_NOP,   F3_NOP,   CD_NEG, BR_JMP,  A_BRN + CA_W'(2));
      A_BRN + CA_W'(1):   word = mk(F1_NOP,   F2_NOP,   F3_NOP,   CD_ALW, BR_JMP,  FETCH_ORG);
      A_BRN + CA_W'(2):   word = mk(F1_NOP,   F2_NOP,   F3_NOP,   CD_IND, BR_CALL, INDIR_ORG);
      A_BRN + CA_W'(3):   word = mk(F1_NOP,   F2_NOP,   F3_ARTPC, CD_ALW, BR_JMP,  FETCH_ORG);
      // store accumulator
      A_STO:              word = mk(F1_NOP,   F2_NOP,   F3_NOP,   CD_IND, BR_CALL, INDIR_ORG);
      A_STO + CA_W'(1):   word = mk(F1_NOP,   F2_ACTDR, F3_NOP,   CD_ALW, BR_JMP,  A_STO + CA_W'(2));
      A_STO + CA_W'(2):   word = mk(F1_WRITE, F2_NOP,   F3_NOP,   CD_ALW, BR_JMP,  FETCH_ORG);
      // swap accumulator and memory
      A_XCH:              word = mk(F1_NOP,   F2_NOP,   F3_NOP,   CD_IND, BR_CALL, INDIR_ORG);
      A_XCH + CA_W'(1):   word = mk(F1_NOP,   F2_READ,  F3_NOP,   CD_ALW, BR_JMP,  A_XCH + CA_W'(2));
      A_XCH + CA_W'(2):   word = mk(F1_DRTAC, F2_ACTDR, F3_NOP,   CD_ALW, BR_JMP,  A_XCH + CA_W'(3));
      A_XCH + CA_W'(3):   word = mk(F1_WRITE, F2_NOP,   F3_NOP,   CD_ALW, BR_JMP,  FETCH_ORG);
      // fetch
      FETCH_ORG:          word = mk(F1_PCTAR, F2_NOP,   F3_NOP,   CD_ALW, BR_JMP,  FETCH_ORG + CA_W'(1));
      FETCH_ORG+CA_W'(1): word = mk(F1_NOP,   F2_READ,  F3_INCPC, CD_ALW, BR_JMP,  FETCH_ORG + CA_W'(2));
      FETCH_ORG+CA_W'(2): word = mk(F1_DRTAR, F2_NOP,   F3_NOP,   CD_ALW, BR_MAP,  '0);
      // indirect operand subroutine
      INDIR_ORG:          word = mk(F1_NOP,   F2_READ,  F3_NOP,   CD_ALW, BR_JMP,  INDIR_ORG + CA_W'(1));
      INDIR_ORG+CA_W'(1): word = mk(F1_DRTAR, F2_NOP,   F3_NOP,   CD_ALW, BR_RET,  '0);
      // unused entries and spare opcodes go back to fetch
      default:            word = mk(F1_NOP,   F2_NOP,   F3_NOP,   CD_ALW, BR_JMP,  FETCH_ORG);
    endcase
  end
endmodule

// File: rtl/ucpu_sequencer.sv
module ucpu_sequencer
  import ucpu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  cond_e           cd,
  input  br_e             br,
  input  logic [CA_W-1:0] ad,
  input  logic            i_bit,
  input  logic            s_bit,
  input  logic            z_bit,
  input  logic [OP_W-1:0] map_op,
  output logic            test,
  output logic [CA_W-1:0] car,
  output logic [CA_W-1:0] sbr
);
  logic [CA_W-1:0] car_inc;
  logic [CA_W-1:0] car_nxt;
  logic [CA_W-1:0] map_addr;
  logic            sbr_ld;

  assign car_inc  = car + CA_W'(1);
  assign map_addr = CA_W'({map_op, {MAP_SH{1'b0}}});

  always_comb begin
    case (cd)
      CD_ALW:  test = 1'b1;
      CD_IND:  test = i_bit;
      CD_NEG:  test = s_bit;
      CD_ZERO: test = z_bit;
      default: test = 1'b1;
    endcase
  end

  always_comb begin
    car_nxt = car_inc;
    sbr_ld  = 1'b0;
    case (br)
      BR_JMP:  if (test) car_nxt = ad;
      BR_CALL: if (test) begin
                 car_nxt = ad;
                 sbr_ld  = 1'b1;
               end
      BR_RET:  car_nxt = sbr;
      BR_MAP:  car_nxt = map_addr;
      default: car_nxt = car_inc;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      car <= FETCH_ORG;
      sbr <= '0;
    end else begin
      car <= car_nxt;
      if (sbr_ld) sbr <= car_inc;
    end
  end
endmodule

// File: rtl/ucpu_datapath.sv
module ucpu_datapath
  import ucpu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DEC_N-1:0]  f1h,
  input  logic [DEC_N-1:0]  f2h,
  input  logic [DEC_N-1:0]  f3h,
  input  logic              load_en,
  input  logic [MA_W-1:0]   load_addr,
  input  logic [DATA_W-1:0] load_data,
  input  logic [MA_W-1:0]   peek_addr,
  output logic [DATA_W-1:0] peek_data,
  output logic [DATA_W-1:0] ac,
  output logic [DATA_W-1:0] dr,
  output logic [MA_W-1:0]   pc
);
  localparam int MEM_D = 1 << MA_W;

  logic [DATA_W-1:0] mem [MEM_D];
  logic [MA_W-1:0]   ar;
  logic [DATA_W-1:0] mem_q;
  logic              ar_ld;
  logic [MA_W-1:0]   ar_src;
  logic [DATA_W-1:0] ac_nxt;
  logic              unused_nop;

  assign unused_nop = ^{f1h[F1_NOP], f2h[F2_NOP], f3h[F3_NOP], f3h[DEC_N-1]};

  assign mem_q     = mem[ar];
  assign peek_data = mem[peek_addr];

  always_ff @(posedge clk) begin
    if (load_en)                      mem[load_addr] <= load_data;
    else if (rst_n && f1h[F1_WRITE])  mem[ar]        <= dr;
  end

  // address register: two sources, source mux steered by the DR transfer line
  assign ar_ld  = f1h[F1_DRTAR] | f1h[F1_PCTAR];
  assign ar_src = f1h[F1_DRTAR] ? dr[MA_W-1:0] : pc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ar <= '0;
    else if (ar_ld) ar <= ar_src;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pc <= '0;
    else if (f3h[F3_ARTPC])    pc <= ar;
    else if (f3h[F3_INCPC])    pc <= pc + MA_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                dr <= '0;
    else if (f2h[F2_READ])     dr <= mem_q;
    else if (f2h[F2_ACTDR])    dr <= ac;
    else if (f2h[F2_INCDR])    dr <= dr + DATA_W'(1);
    else if (f2h[F2_PCTDR])    dr <= DATA_W'(pc);
  end

  always_comb begin
    ac_nxt = ac;
    if (f1h[F1_ADD])        ac_nxt = ac + dr;
    else if (f1h[F1_CLRAC]) ac_nxt = '0;
    else if (f1h[F1_INCAC]) ac_nxt = ac + DATA_W'(1);
    else if (f1h[F1_DRTAC]) ac_nxt = dr;
    else if (f2h[F2_SUB])   ac_nxt = ac - dr;
    else if (f2h[F2_OR])    ac_nxt = ac | dr;
    else if (f2h[F2_AND])   ac_nxt = ac & dr;
    else if (f3h[F3_XOR])   ac_nxt = ac ^ dr;
    else if (f3h[F3_COM])   ac_nxt = ~ac;
    else if (f3h[F3_SHL])   ac_nxt = {ac[DATA_W-2:0], 1'b0};
    else if (f3h[F3_SHR])   ac_nxt = {1'b0, ac[DATA_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ac <= '0;
    else        ac <= ac_nxt;
  end
endmodule

// File: rtl/ucode_acc_cpu.sv
module ucode_acc_cpu
  import ucpu_pkg::*;
#(
  parameter int D_W = DATA_W,
  parameter int A_W = MA_W,
  parameter int C_W = CA_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_en,
  input  logic [A_W-1:0] load_addr,
  input  logic [D_W-1:0] load_data,
  input  logic [A_W-1:0] peek_addr,
  output logic [D_W-1:0] peek_data,
  output logic [D_W-1:0] ac_out,
  output logic [A_W-1:0] pc_out,
  output logic [C_W-1:0] car_out
);
  uword_t                         uw;
  logic [CA_W-1:0]                car;
  logic [CA_W-1:0]                sbr;
  logic                           test_bit;
  br_e                            br_sel;
  cond_e                          cd_sel;
  logic [CA_W-1:0]                ad_fld;
  logic [FLD_N-1:0][FLD_W-1:0]    fld;
  logic [FLD_N-1:0][DEC_N-1:0]    hot;
  logic [DEC_N-1:0]               f1h;
  logic [DEC_N-1:0]               f2h;
  logic [DEC_N-1:0]               f3h;
  logic [DATA_W-1:0]              ac;
  logic [DATA_W-1:0]              dr;
  logic [MA_W-1:0]                pc;

  ucpu_ctrl_rom u_rom (.addr(car), .word(uw));

  assign br_sel = uw.br;
  assign cd_sel = uw.cd;
  assign ad_fld = uw.ad;
  assign fld[0] = uw.f1;
  assign fld[1] = uw.f2;
  assign fld[2] = uw.f3;

  for (genvar g = 0; g < FLD_N; g++) begin : g_dec
    ucpu_field_dec #(.W(FLD_W)) u_dec (.code(fld[g]), .hot(hot[g]));
  end

  assign f1h = hot[0];
  assign f2h = hot[1];
  assign f3h = hot[2];

  ucpu_sequencer u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .cd     (cd_sel),
    .br     (br_sel),
    .ad     (ad_fld),
    .i_bit  (dr[DATA_W-1]),
    .s_bit  (ac[DATA_W-1]),
    .z_bit  (ac == '0),
    .map_op (dr[DATA_W-2 -: OP_W]),
    .test   (test_bit),
    .car    (car),
    .sbr    (sbr)
  );

  ucpu_datapath u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .f1h       (f1h),
    .f2h       (f2h),
    .f3h       (f3h),
    .load_en   (load_en),
    .load_addr (MA_W'(load_addr)),
    .load_data (DATA_W'(load_data)),
    .peek_addr (MA_W'(peek_addr)),
    .peek_data (peek_data),
    .ac        (ac),
    .dr        (dr),
    .pc        (pc)
  );

  assign ac_out  = D_W'(ac);
  assign pc_out  = A_W'(pc);
  assign car_out = C_W'(car);
endmodule

// File: rtl/ucpu_checker.sv
module ucpu_checker
  import ucpu_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [CA_W-1:0]   car,
  input logic [CA_W-1:0]   sbr,
  input logic              test_bit,
  input br_e               br_sel,
  input logic [CA_W-1:0]   ad_fld,
  input logic [DATA_W-1:0] ac,
  input logic [DATA_W-1:0] dr,
  input logic [MA_W-1:0]   pc,
  input logic [DEC_N-1:0]  f1h,
  input logic [DEC_N-1:0]  f2h,
  input logic [DEC_N-1:0]  f3h
);
  logic [10:0] ac_writers;
  assign ac_writers = {f1h[F1_ADD], f1h[F1_CLRAC], f1h[F1_INCAC], f1h[F1_DRTAC],
                       f2h[F2_SUB], f2h[F2_OR], f2h[F2_AND],
                       f3h[F3_XOR], f3h[F3_COM], f3h[F3_SHL], f3h[F3_SHR]};

  // R2: fetch advances the program counter in its second step
  a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (car == FETCH_ORG + CA_W'(1)) |=> (pc == $past(pc) + MA_W'(1)));

  // R2: dispatch lands on the four-aligned opcode entry
  a_r2_map_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (car == FETCH_ORG + CA_W'(2)) |=>
      (car == CA_W'({$past(dr[DATA_W-2 -: OP_W]), {MAP_SH{1'b0}}})));

  // R3: never two accumulator writers in one microword
  a_r3_single_ac_writer: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ac_writers) <= 1);

  // R4: taken call links the following address
  a_r4_call_link: assert property (@(posedge clk) disable iff (!rst_n)
    (br_sel == BR_CALL && test_bit) |=>
      (car == $past(ad_fld) && sbr == $past(car) + CA_W'(1)));

  // R4: return resumes at the linked address
  a_r4_ret_target: assert property (@(posedge clk) disable iff (!rst_n)
    (br_sel == BR_RET) |=> (car == $past(sbr)));

  // R5: accumulate step sums accumulator and data register
  a_r5_add_result: assert property (@(posedge clk) disable iff (!rst_n)
    f1h[F1_ADD] |=> (ac == $past(ac) + $past(dr)));

  // R11: false condition falls through
  a_r11_fall_through: assert property (@(posedge clk) disable iff (!rst_n)
    ((br_sel == BR_JMP || br_sel == BR_CALL) && !test_bit) |=>
      (car == $past(car) + CA_W'(1)));
endmodule

bind ucode_acc_cpu ucpu_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .car      (car),
  .sbr      (sbr),
  .test_bit (test_bit),
  .br_sel   (br_sel),
  .ad_fld   (ad_fld),
  .ac       (ac),
  .dr       (dr),
  .pc       (pc),
  .f1h      (f1h),
  .f2h      (f2h),
  .f3h      (f3h)
);

// File: tb/tb_ucode_acc_cpu.sv
module tb_ucode_acc_cpu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_en = 1'b0;
  logic [10:0] load_addr = '0;
  logic [15:0] load_data = '0;
  logic [10:0] peek_addr = '0;
  logic [15:0] peek_data;
  logic [15:0] ac_out;
  logic [10:0] pc_out;
  logic [6:0]  car_out;

  localparam logic [6:0] FETCH = 7'd64;

  typedef struct {
    logic [10:0] pc;
    logic [15:0] ac;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  int   cyc = 0;
  logic timeout = 1'b0;

  ucode_acc_cpu dut (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
    .load_data(load_data), .peek_addr(peek_addr), .peek_data(peek_data),
    .ac_out(ac_out), .pc_out(pc_out), .car_out(car_out)
  );

  always #10 clk = ~clk;  // 20 ns period, 50 MHz

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 5000) timeout <= 1'b1;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ins(input logic ind, input logic [3:0] op, input logic [10:0] a);
    return {ind, op, a};
  endfunction

  task automatic put(input logic [10:0] a, input logic [15:0] d);
    @(negedge clk);
    load_en = 1'b1;
    load_addr = a;
    load_data = d;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic push_exp(input logic [10:0] pc, input logic [15:0] ac, input string tag);
    exp_t e;
    e.pc = pc;
    e.ac = ac;
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic peek_chk(input logic [10:0] a, input logic [15:0] exp, input string tag);
    peek_addr = a;
    #1;
    check(tag, 32'(peek_data), 32'(exp));
  endtask

  // monitor: on each fetch entry compare the architectural state with the scoreboard
  always @(negedge clk) begin
    if (rst_n && car_out == FETCH && sb_q.size() != 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check({e.tag, " pc"}, 32'(pc_out), 32'(e.pc));
      check({e.tag, " ac"}, 32'(ac_out), 32'(e.ac));
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1: reset state
    check("R1 car in reset", 32'(car_out), 32'(FETCH));
    check("R1 pc in reset", 32'(pc_out), 32'd0);
    check("R1 ac in reset", 32'(ac_out), 32'd0);

    // program (R10 direct load during reset)
    put(11'd0,  ins(1'b0, 4'd0,  11'd100));  // add direct
    put(11'd1,  ins(1'b1, 4'd0,  11'd101));  // add indirect
    put(11'd2,  ins(1'b0, 4'd2,  11'd200));  // store direct
    put(11'd3,  ins(1'b0, 4'd3,  11'd103));  // exchange direct
    put(11'd4,  ins(1'b0, 4'd5,  11'd109));  // spare opcode
    put(11'd5,  ins(1'b1, 4'd1,  11'd104));  // branch indirect, taken
    put(11'd6,  ins(1'b0, 4'd0,  11'd100));  // skipped
    put(11'd10, ins(1'b0, 4'd0,  11'd105));  // add with wrap
    put(11'd11, ins(1'b0, 4'd1,  11'd20));   // branch not taken
    put(11'd12, ins(1'b1, 4'd2,  11'd106));  // store indirect
    put(11'd13, ins(1'b1, 4'd3,  11'd107));  // exchange indirect
    put(11'd14, ins(1'b0, 4'd1,  11'd0));    // branch not taken
    put(11'd15, ins(1'b1, 4'd15, 11'd0));    // spare opcode, indirect flag set
    put(11'd16, ins(1'b0, 4'd0,  11'd108));  // make accumulator negative
    put(11'd17, ins(1'b0, 4'd1,  11'd17));   // loop on itself
    put(11'd100, 16'h0005);
    put(11'd101, 16'd102);
    put(11'd102, 16'h0007);
    put(11'd103, 16'hFFF0);
    put(11'd104, 16'd10);
    put(11'd105, 16'h0010);
    put(11'd106, 16'd201);
    put(11'd107, 16'd202);
    put(11'd108, 16'h8000);
    put(11'd109, 16'h4321);
    put(11'd200, 16'hAAAA);
    put(11'd201, 16'h5555);
    put(11'd202, 16'h1234);

    peek_chk(11'd103, 16'hFFF0, "R10 load then peek");
    peek_chk(11'd17, ins(1'b0, 4'd1, 11'd17), "R10 program word");

    // scoreboard driver: expected state at each fetch entry
    push_exp(11'd0,  16'h0000, "R1 first fetch");
    push_exp(11'd1,  16'h0005, "R5 add direct");
    push_exp(11'd2,  16'h000C, "R5 R4 add indirect");
    push_exp(11'd3,  16'h000C, "R7 store keeps ac");
    push_exp(11'd4,  16'hFFF0, "R8 exchange direct");
    push_exp(11'd5,  16'hFFF0, "R9 spare opcode");
    push_exp(11'd10, 16'hFFF0, "R6 R4 branch taken indirect");
    push_exp(11'd11, 16'h0000, "R5 add wraps");
    push_exp(11'd12, 16'h0000, "R6 R11 branch not taken");
    push_exp(11'd13, 16'h0000, "R7 store indirect");
    push_exp(11'd14, 16'h1234, "R8 exchange indirect");
    push_exp(11'd15, 16'h1234, "R6 branch positive");
    push_exp(11'd16, 16'h1234, "R9 spare opcode indirect");
    push_exp(11'd17, 16'h9234, "R5 add to negative");
    push_exp(11'd17, 16'h9234, "R6 branch to self");
    push_exp(11'd17, 16'h9234, "R2 R6 loop steady");

    @(posedge clk);
    #1 rst_n = 1'b1;

    wait (sb_q.size() == 0 || timeout);
    @(negedge clk);
    if (timeout) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d entries left expected 0", sb_q.size());
    end

    peek_chk(11'd200, 16'h000C, "R7 direct store word");
    peek_chk(11'd201, 16'h0000, "R7 indirect store word");
    peek_chk(11'd103, 16'h000C, "R8 direct exchange word");
    peek_chk(11'd202, 16'h0000, "R8 indirect exchange word");
    peek_chk(11'd109, 16'h4321, "R9 spare opcode leaves memory");
    peek_chk(11'd100, 16'h0005, "R5 operand untouched");
    peek_chk(11'd106, 16'd201,  "R4 pointer untouched");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule